// File: doc/BRIEF.md
# Input-Pin Change Reporter for a Button Interrupt Endpoint

This block watches a small general-purpose pin port and tells the host when a button changes. Each pin passes through a two-flop synchronizer. A prescaler produces a poll instant every `POLL_CYCLES` clocks, which is about 17 ms at the system clock. At each poll the block keeps only the pins that configuration marks as inputs. It then compares them with the value it kept at the previous poll.

When at least one enabled input has changed, the block builds a two-byte status report. The first byte holds the masked pin levels. The second byte holds two link-status flags: whether the device is powered from the bus and whether the link runs at high speed. The report goes to the interrupt-endpoint transmitter as two byte beats over a valid/ready handshake. A report still waiting to be sent is replaced by the newest one, so a slow host only ever sees the latest state.

Top module: `pinwatch_hid_report`

## Requirements
- R1: A poll instant occurs exactly once every `POLL_CYCLES` clock cycles, the first on the `POLL_CYCLES`-th rising edge after reset is released. Pin changes between polls are seen only at the next poll.
- R2: Every pin passes through two synchronizing flops. The value a poll uses is the level that was present on `pin_in` two rising edges before the poll edge.
- R3: After reset, the first poll only stores the reference value and never produces a report.
- R4: A report is queued only when the masked input value at a poll differs from the masked value at the previous poll. A change on a pin configured as an output (`pin_is_input` bit = 0) queues nothing.
- R5: Byte 0 carries pin n in bit n for n = 0..5. Any pin whose `pin_is_input` bit is 0 reads as 0, and bits 7..6 are 0.
- R6: Byte 1 bit 0 is `bus_powered` and bit 1 is `high_speed`, both sampled at the poll that found the change. Bits 7..2 are 0. A change of either flag alone queues nothing.
- R7: A report is sent as two beats: byte 0 with `tx_last` = 0, then byte 1 with `tx_last` = 1. A beat completes on a rising edge where `tx_valid` and `tx_ready` are both 1.
- R8: While `tx_valid` is 1 and `tx_ready` is 0, `tx_valid`, `tx_data` and `tx_last` keep their values on the next cycle.
- R9: A report being sent is never altered. Changes detected during that time overwrite one waiting slot, so at most one further report follows, and it carries the state of the latest change.
- R10: While `rst_n` is 0, `tx_valid` is 0 and all poll, reference and report state returns to its default.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| pin_in | input | NUM_PINS | Raw asynchronous pin levels |
| pin_is_input | input | NUM_PINS | Per-pin direction from configuration, 1 = input watched |
| bus_powered | input | 1 | Status flag: device draws power from the bus |
| high_speed | input | 1 | Status flag: link runs at high speed |
| tx_valid | output | 1 | A report beat is presented |
| tx_data | output | 8 | Current report byte |
| tx_last | output | 1 | Marks the second (final) byte of a report |
| tx_ready | input | 1 | Transmitter accepts the current beat |

## Verification
The bench builds the block with `POLL_CYCLES` = 16 and the default six pins. With this setting hundreds of poll instants fit in a few thousand cycles. Pin edges can also be placed at every offset around a poll edge, which exposes the synchronizer depth and poll timing exactly. The short interval also lets back-pressure last across several polls, so the single waiting slot is overwritten repeatedly while a report is stalled. Direction-mask changes, flag-only changes and random ready patterns are then swept over many reports.

// File: rtl/pinwatch_pkg.sv
package pinwatch_pkg;

  typedef enum logic [1:0] {
    TX_IDLE  = 2'd0,
    TX_BYTE0 = 2'd1,
    TX_BYTE1 = 2'd2
  } tx_state_e;

  // Pin byte: masked levels in the low bits, upper bits forced to zero.
  function automatic logic [7:0] pin_byte(input logic [7:0] raw,
                                          input logic [7:0] dir,
                                          input int unsigned npins);
    logic [7:0] keep;
    keep = 8'((9'd1 << npins) - 9'd1);
    return raw & dir & keep;
  endfunction

  // Status byte: bit 0 bus power, bit 1 link speed.
  function automatic logic [7:0] flag_byte(input logic bus_pwr,
                                           input logic hi_spd);
    return {6'b0, hi_spd, bus_pwr};
  endfunction

endpackage

// File: rtl/pinwatch_sync.sv
module pinwatch_sync #(
  parameter int WIDTH = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] async_in,
  output logic [WIDTH-1:0] sync_out
);
  logic [WIDTH-1:0] stage_a;

  for (genvar g = 0; g < WIDTH; g++) begin : g_bit
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        stage_a[g]  <= 1'b0;
        sync_out[g] <= 1'b0;
      end else begin
        stage_a[g]  <= async_in[g];
        sync_out[g] <= stage_a[g];
      end
    end
  end
endmodule

// File: rtl/pinwatch_poll_timer.sv
module pinwatch_poll_timer #(
  parameter int POLL_CYCLES = 4_250_000
) (
  input  logic clk,
  input  logic rst_n,
  output logic poll_tick
);
  localparam int CNT_W = (POLL_CYCLES > 2) ? $clog2(POLL_CYCLES) : 1;
  localparam logic [CNT_W-1:0] LAST = CNT_W'(POLL_CYCLES - 1);

  logic [CNT_W-1:0] cnt_q;

  assign poll_tick = (cnt_q == LAST);

  always_ff @(posedge clk) begin
    if (!rst_n)         cnt_q <= '0;
    else if (poll_tick) cnt_q <= '0;
    else                cnt_q <= cnt_q + 1'b1;
  end

  if (POLL_CYCLES > 1) begin : g_spacing
    // R1
    tick_spacing_chk: assert property (@(posedge clk) disable iff (!rst_n)
      poll_tick |=> !poll_tick);
  end
endmodule

// File: rtl/pinwatch_change_det.sv
module pinwatch_change_det #(
  parameter int NUM_PINS = 6
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                poll_tick,
  input  logic [NUM_PINS-1:0] pins_sync,
  input  logic [NUM_PINS-1:0] dir_in,
  output logic [NUM_PINS-1:0] masked_now,
  output logic                primed,
  output logic                chg_evt
);
  logic [NUM_PINS-1:0] ref_q;

  assign masked_now = pins_sync & dir_in;
  assign chg_evt    = poll_tick && primed && (masked_now != ref_q);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ref_q  <= '0;
      primed <= 1'b0;
    end else if (poll_tick) begin
      ref_q  <= masked_now;
      primed <= 1'b1;
    end
  end

  // R3
  first_poll_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (poll_tick && !primed) |-> !chg_evt);
endmodule

// File: rtl/pinwatch_report_tx.sv
module pinwatch_report_tx
  import pinwatch_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        chg_evt,
  input  logic [15:0] new_report,
  input  logic        tx_ready,
  output logic        tx_valid,
  output logic [7:0]  tx_data,
  output logic        tx_last,
  output logic        load_evt,
  output logic        hold_pend
);
  tx_state_e   st_q;
  logic [15:0] hold_word;
  logic [15:0] out_word;

  assign load_evt = hold_pend && ((st_q == TX_IDLE) || (st_q == TX_BYTE1 && tx_ready));
  assign tx_valid = (st_q != TX_IDLE);
  assign tx_last  = (st_q == TX_BYTE1);
  assign tx_data  = (st_q == TX_BYTE1) ? out_word[15:8] : out_word[7:0];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_q      <= TX_IDLE;
      hold_word <= '0;
      out_word  <= '0;
      hold_pend <= 1'b0;
    end else begin
      case (st_q)
        TX_IDLE:  if (load_evt) st_q <= TX_BYTE0;
        TX_BYTE0: if (tx_ready) st_q <= TX_BYTE1;
        TX_BYTE1: if (tx_ready) st_q <= load_evt ? TX_BYTE0 : TX_IDLE;
        default:  st_q <= TX_IDLE;
      endcase
      if (load_evt) out_word <= hold_word;
      if (chg_evt) begin
        hold_word <= new_report;
        hold_pend <= 1'b1;
      end else if (load_evt) begin
        hold_pend <= 1'b0;
      end
    end
  end

  // R8
  stall_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_valid && !tx_ready) |=> (tx_valid && $stable(tx_data) && $stable(tx_last)));

  // R7
  beat_order_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_valid && !tx_last && tx_ready) |=> (tx_valid && tx_last));
endmodule

// File: rtl/pinwatch_hid_report.sv
module pinwatch_hid_report
  import pinwatch_pkg::*;
#(
  parameter int NUM_PINS    = 6,
  parameter int POLL_CYCLES = 4_250_000
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [NUM_PINS-1:0] pin_in,
  input  logic [NUM_PINS-1:0] pin_is_input,
  input  logic                bus_powered,
  input  logic                high_speed,
  output logic                tx_valid,
  output logic [7:0]          tx_data,
  output logic                tx_last,
  input  logic                tx_ready
);
  logic [NUM_PINS-1:0] pins_sync;
  logic [NUM_PINS-1:0] masked_now;
  logic                poll_tick;
  logic                primed;
  logic                chg_evt;
  logic                load_evt;
  logic                hold_pend;
  logic [15:0]         new_report;

  pinwatch_sync #(.WIDTH(NUM_PINS)) u_sync (
    .clk(clk), .rst_n(rst_n), .async_in(pin_in), .sync_out(pins_sync));

  pinwatch_poll_timer #(.POLL_CYCLES(POLL_CYCLES)) u_timer (
    .clk(clk), .rst_n(rst_n), .poll_tick(poll_tick));

  pinwatch_change_det #(.NUM_PINS(NUM_PINS)) u_det (
    .clk(clk), .rst_n(rst_n), .poll_tick(poll_tick), .pins_sync(pins_sync),
    .dir_in(pin_is_input), .masked_now(masked_now), .primed(primed),
    .chg_evt(chg_evt));

  assign new_report = {flag_byte(bus_powered, high_speed),
                       pin_byte(8'(masked_now), 8'(pin_is_input), NUM_PINS)};

  pinwatch_report_tx u_tx (
    .clk(clk), .rst_n(rst_n), .chg_evt(chg_evt), .new_report(new_report),
    .tx_ready(tx_ready), .tx_valid(tx_valid), .tx_data(tx_data),
    .tx_last(tx_last), .load_evt(load_evt), .hold_pend(hold_pend));

  // R4
  change_only_at_poll_chk: assert property (@(posedge clk) disable iff (!rst_n)
    chg_evt |-> poll_tick);

  // R6
  flag_byte_reserved_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_valid && tx_last) |-> (tx_data[7:2] == 6'b0));

  // R5
  pin_byte_reserved_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_valid && !tx_last) |-> (tx_data[7:6] == 2'b0));

  // R9
  load_needs_pending_chk: assert property (@(posedge clk) disable iff (!rst_n)
    load_evt |=> (tx_valid && !tx_last));
endmodule

// File: tb/pinwatch_hid_report_tb_top.sv
module pinwatch_hid_report_tb_top;
  localparam int P = 16;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [5:0] pin_in = '0;
  logic [5:0] pin_is_input = '0;
  logic       bus_powered = 1'b0;
  logic       high_speed = 1'b0;
  logic       tx_ready = 1'b0;
  logic       tx_valid;
  logic [7:0] tx_data;
  logic       tx_last;

  int checks = 0;
  int fails = 0;
  string cur_req = "R10";
  bit done = 0;

  always #2 clk = ~clk;  // 250 MHz

  pinwatch_hid_report #(.NUM_PINS(6), .POLL_CYCLES(P)) dut_i (
    .clk(clk), .rst_n(rst_n), .pin_in(pin_in), .pin_is_input(pin_is_input),
    .bus_powered(bus_powered), .high_speed(high_speed), .tx_valid(tx_valid),
    .tx_data(tx_data), .tx_last(tx_last), .tx_ready(tx_ready));

  // Behavioural reference model.
  logic [5:0] syncq[$];
  int   poll_cnt;
  bit   m_primed;
  int   m_ref;
  int   m_phase;     // 0 none, 1 first byte, 2 second byte
  int   m_word;
  int   m_hold;
  bit   m_pend;
  int   reports_done;

  always @(posedge clk) begin
    if (!rst_n) begin
      syncq = '{6'd0, 6'd0};
      poll_cnt = 0; m_primed = 0; m_ref = 0;
      m_phase = 0; m_word = 0; m_hold = 0; m_pend = 0;
    end else begin
      int seen, msk, flags;
      bit poll, chg, take;
      seen  = int'(syncq[0]);
      msk   = seen & int'(pin_is_input);
      poll  = (poll_cnt == P - 1);
      chg   = poll && m_primed && (msk != m_ref);
      flags = (high_speed ? 2 : 0) + (bus_powered ? 1 : 0);
      take  = m_pend && (m_phase == 0 || (m_phase == 2 && tx_ready));
      if (m_phase == 2 && tx_ready) reports_done++;
      if (take) begin m_phase = 1; m_word = m_hold; end
      else if (m_phase == 1 && tx_ready) m_phase = 2;
      else if (m_phase == 2 && tx_ready) m_phase = 0;
      if (chg) begin m_hold = flags * 256 + msk; m_pend = 1; end
      else if (take) m_pend = 0;
      if (poll) begin m_ref = msk; m_primed = 1; end
      poll_cnt = poll ? 0 : poll_cnt + 1;
      syncq.push_back(pin_in);
      void'(syncq.pop_front());
    end
  end

  // Compare on every falling edge.
  always @(negedge clk) begin
    if (!done) begin
      bit ev; logic [7:0] ed; bit el;
      ev = (m_phase != 0);
      ed = (m_phase == 2) ? 8'(m_word >> 8) : 8'(m_word);
      el = (m_phase == 2);
      checks++;
      if (tx_valid !== ev || (ev && (tx_data !== ed || tx_last !== el))) begin
        fails++;
        $display("FAIL %s t=%0t valid/data/last got %b/%h/%b exp %b/%h/%b",
                 cur_req, $time, tx_valid, tx_data, tx_last, ev, ed, el);
      end
    end
  end

  task automatic cyc(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic direct_check(string req, int got, int exp);
    checks++;
    if (got != exp) begin
      fails++;
      $display("FAIL %s got %0d exp %0d", req, got, exp);
    end
  endtask

  task automatic finish_run();
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    int base;
    // R10: outputs idle while reset is held
    cyc(5);
    direct_check("R10", int'(tx_valid), 0);
    pin_in = 6'h15; pin_is_input = 6'h3F; tx_ready = 1'b1;
    cyc(3);
    direct_check("R10", int'(tx_valid), 0);
    rst_n = 1'b1;

    // R3: first poll loads reference only
    cur_req = "R3";
    base = reports_done;
    cyc(3 * P);
    direct_check("R3", reports_done - base, 0);

    // R4: an input change yields one report
    cur_req = "R4";
    base = reports_done;
    pin_in = 6'h14;
    cyc(3 * P);
    direct_check("R4", reports_done - base, 1);

    // R5: direction mask zeroes output pins; output-pin toggles ignored
    cur_req = "R5";
    pin_is_input = 6'h0F;
    cyc(3 * P);
    base = reports_done;
    pin_in = 6'h24;
    cyc(3 * P);
    direct_check("R4", reports_done - base, 0);

    // R6: flags alone do nothing, then travel with a pin change
    cur_req = "R6";
    base = reports_done;
    bus_powered = 1'b1; high_speed = 1'b1;
    cyc(3 * P);
    direct_check("R6", reports_done - base, 0);
    pin_in = 6'h25;
    cyc(3 * P);
    direct_check("R6", reports_done - base, 1);

    // R8 and R9: stalled transmitter, several changes overwrite the waiting slot
    cur_req = "R9";
    tx_ready = 1'b0;
    pin_in = 6'h24;
    cyc(2 * P);
    pin_in = 6'h26; cyc(P);
    pin_in = 6'h27; cyc(P);
    pin_in = 6'h2B; cyc(P);
    base = reports_done;
    tx_ready = 1'b1;
    cyc(3 * P);
    direct_check("R9", reports_done - base, 2);

    // R2 and R1: pin edges at every offset around the poll edge
    cur_req = "R2";
    pin_is_input = 6'h3F;
    for (int off = 0; off < P + 3; off++) begin
      pin_in = pin_in ^ 6'h01;
      cyc(P + off);
    end

    // R7: random traffic with random ready
    cur_req = "R7";
    begin
      logic [15:0] lf = 16'hACE1;
      for (int k = 0; k < 1500; k++) begin
        lf = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
        tx_ready = lf[0] | lf[3];
        if (lf[7:5] == 3'd0) pin_in = lf[13:8];
        if (lf[15:11] == 5'd0) pin_is_input = lf[10:5];
        if (lf[9:4] == 6'd0) bus_powered = ~bus_powered;
        cyc(1);
      end
    end

    // R10: reset mid-run returns to idle
    cur_req = "R10";
    tx_ready = 1'b0;
    rst_n = 1'b0;
    cyc(2);
    direct_check("R10", int'(tx_valid), 0);
    rst_n = 1'b1;
    cyc(2 * P);
    finish_run();
  end
endmodule